// File: doc/BRIEF.md
# Packet-Driven Register Bank Slave

This block turns a stream of command packets, delivered one byte per clock, into 32-bit register reads and writes. Each packet opens with a start flag, and that first byte also carries a kind bit: 0 for a write, 1 for a read. The packet closes with an end flag. A write packet carries the register offset and then the data word. A read packet carries only the offset. The block then returns the word as four response bytes, least significant first.

Most offsets are served inside the block:

- a read-only identification word;
- a self-clearing subsystem reset register, which drives six timed reset pulses;
- two five-bit lane-enable registers;
- two start registers.

The block also owns one parameterised address window (offsets 0x0400 to 0x04FF by default). Commands in that window go out on a simple register bus, and the read data comes back with one cycle of latency. Commands to any other offset do nothing, and reads from them return zero. A packet whose length is wrong for its kind is dropped and sets a sticky error flag.

Top module: `pkt_reg_slave`

## Requirements
- R1: A write packet is exactly 6 bytes: offset bits 7:0, offset bits 15:8, then data bits 7:0, 15:8, 23:16 and 31:24. A write whose offset falls in the bus window raises `reg_wr_en` for exactly one cycle, with that offset on `reg_addr` and that word on `reg_wdata`.
- R2: A read packet is exactly 2 bytes: offset bits 7:0, then bits 15:8. It is answered by exactly 4 bytes on `out_byte`, least significant first, each marked by `out_valid`. `out_last` is set on the fourth byte only.
- R3: Offset 0x0580 reads back the parameter `ID_VALUE`. A write to 0x0580 leaves that value unchanged.
- R4: In the reset register at offset 0x0504, writing 1 to bit k (k = 0..5) drives `sub_rst[k]` high for exactly `RST_CYCLES` consecutive cycles (16 by default), after which the bit clears by itself. A bit that is already pulsing is not retriggered. A read of 0x0504 returns the bits that are currently pulsing.
- R5: Offsets 0x0134 and 0x0210 hold five-bit lane enables, driven on `lane_en_a` and `lane_en_b` respectively. In each, bit 0 is the clock lane and bits 1 to 4 are data lanes 0 to 3. A read returns those five bits, with all higher bits zero.
- R6: Offsets 0x0104 and 0x0204 drive `start_a` and `start_b`. Writing a word with bit 0 set raises the output, and writing a word with bit 0 clear lowers it.
- R7: A write packet of any length other than 6 bytes, or a read packet of any length other than 2 bytes, is dropped. It causes no bus strobe, no register change and no response, and it sets `len_err`, which stays set until reset.
- R8: A write to an offset that is neither an internal register nor in the bus window changes no output and raises no bus strobe. A read from such an offset returns 0x00000000.
- R9: A read whose offset falls in the bus window raises `reg_rd_en` for one cycle and returns the `reg_rdata` value presented in the following cycle.
- R10: After reset, all outputs are low, including `len_err`, `lane_en_a`, `lane_en_b`, `start_a`, `start_b` and `sub_rst`.
- R11: Bytes that arrive after an end flag and before the next start flag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_kind | input | 1 | Packet kind, sampled with the start byte: 0 write, 1 read |
| in_byte | input | 8 | Input byte |
| reg_wr_en | output | 1 | Bus write strobe for the window |
| reg_rd_en | output | 1 | Bus read strobe for the window |
| reg_addr | output | 16 | Bus offset |
| reg_wdata | output | 32 | Bus write data |
| reg_rdata | input | 32 | Bus read data, valid the cycle after `reg_rd_en` |
| out_valid | output | 1 | Response byte present |
| out_byte | output | 8 | Response byte |
| out_last | output | 1 | Final response byte |
| sub_rst | output | 6 | Timed subsystem reset pulses |
| lane_en_a | output | 5 | First lane-enable register |
| lane_en_b | output | 5 | Second lane-enable register |
| start_a | output | 1 | First start register |
| start_b | output | 1 | Second start register |
| len_err | output | 1 | Sticky packet-length error |

## Verification
The checker assumes that the host stays quiet while a response is being sent. That is, `in_valid` is never high while `out_valid` is high, so the latched offset cannot shift under a pending read. The bus-window checks also assume that `reg_addr` stays stable from the read strobe into the cycle that follows it. To keep within both assumptions, the stimulus sends each packet as a single burst. After a read, it waits for the whole four-byte response before sending anything else. The modelled bus slave derives its read data from `reg_addr`, which the block holds steady during that time.

// File: rtl/pkt_reg_pkg.sv
package pkt_reg_pkg;
   typedef enum logic {PK_WRITE = 1'b0, PK_READ = 1'b1} pkt_kind_e;

   localparam int unsigned NUM_SUBRST = 6;

   localparam logic [15:0] OFS_ID      = 16'h0580;
   localparam logic [15:0] OFS_SUBRST  = 16'h0504;
   localparam logic [15:0] OFS_LANE_A  = 16'h0134;
   localparam logic [15:0] OFS_LANE_B  = 16'h0210;
   localparam logic [15:0] OFS_START_A = 16'h0104;
   localparam logic [15:0] OFS_START_B = 16'h0204;
endpackage

// File: rtl/pkt_rx_parser.sv
module pkt_rx_parser
   import pkt_reg_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_kind,
   input  logic [7:0]        in_byte,
   output logic              cmd_valid,
   output logic              cmd_read,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic              len_err
);
   localparam int unsigned ADDR_BYTES = ADDR_W / 8;
   localparam int unsigned DATA_BYTES = DATA_W / 8;
   localparam int unsigned WR_LEN     = ADDR_BYTES + DATA_BYTES;
   localparam int unsigned CNT_MAX    = WR_LEN + 1;
   localparam int unsigned CNT_W      = $clog2(WR_LEN + 3);

   if ((ADDR_W % 8) != 0 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("pkt_rx_parser: widths must be whole bytes");
   end

   logic             in_pkt;
   logic [CNT_W-1:0] cnt;
   logic             kind_q;

   logic             take;
   logic [CNT_W-1:0] byte_idx;
   logic             eff_kind;
   logic             len_ok;

   always_comb begin
      take     = in_valid && (in_sop || in_pkt);
      byte_idx = in_sop ? '0 : cnt;
      eff_kind = in_sop ? in_kind : kind_q;
      if (eff_kind == PK_READ) len_ok = (32'(byte_idx) + 1) == ADDR_BYTES;
      else                     len_ok = (32'(byte_idx) + 1) == WR_LEN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_pkt    <= 1'b0;
         cnt       <= '0;
         kind_q    <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
         len_err   <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         if (take) begin
            kind_q <= eff_kind;
            if (32'(byte_idx) < ADDR_BYTES)
               cmd_addr[byte_idx*8 +: 8] <= in_byte;
            else if (32'(byte_idx) < WR_LEN)
               cmd_data[(32'(byte_idx) - ADDR_BYTES)*8 +: 8] <= in_byte;
            cnt <= (32'(byte_idx) == CNT_MAX) ? byte_idx : byte_idx + 1'b1;
            if (in_eop) begin
               in_pkt <= 1'b0;
               if (len_ok) cmd_valid <= 1'b1;
               else        len_err   <= 1'b1;
            end else begin
               in_pkt <= 1'b1;
            end
         end
      end
   end

   assign cmd_read = kind_q;
endmodule

// File: rtl/pkt_reg_bank.sv
module pkt_reg_bank
   import pkt_reg_pkg::*;
#(
   parameter int unsigned     DATA_W     = 32,
   parameter logic [DATA_W-1:0] ID_VALUE = '0,
   parameter int unsigned     RST_CYCLES = 16,
   parameter int unsigned     LANES      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_stb,
   input  logic [15:0]           addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic                  hit,
   output logic [DATA_W-1:0]     rdata,
   output logic [NUM_SUBRST-1:0] sub_rst,
   output logic [LANES-1:0]      lane_a,
   output logic [LANES-1:0]      lane_b,
   output logic                  start_a,
   output logic                  start_b
);
   localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("pkt_reg_bank: RST_CYCLES must be at least 1");
   end
   if (LANES > DATA_W || DATA_W < NUM_SUBRST) begin : g_bad_lanes
      $error("pkt_reg_bank: register fields exceed the data width");
   end

   always_comb begin
      hit   = 1'b1;
      rdata = '0;
      unique case (addr)
         OFS_ID:      rdata = ID_VALUE;
         OFS_SUBRST:  rdata[NUM_SUBRST-1:0] = sub_rst;
         OFS_LANE_A:  rdata[LANES-1:0] = lane_a;
         OFS_LANE_B:  rdata[LANES-1:0] = lane_b;
         OFS_START_A: rdata[0] = start_a;
         OFS_START_B: rdata[0] = start_b;
         default:     hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_a  <= '0;
         lane_b  <= '0;
         start_a <= 1'b0;
         start_b <= 1'b0;
      end else if (wr_stb) begin
         if (addr == OFS_LANE_A)  lane_a  <= wdata[LANES-1:0];
         if (addr == OFS_LANE_B)  lane_b  <= wdata[LANES-1:0];
         if (addr == OFS_START_A) start_a <= wdata[0];
         if (addr == OFS_START_B) start_b <= wdata[0];
      end
   end

   for (genvar k = 0; k < NUM_SUBRST; k++) begin : g_pulse
      logic [RC_W-1:0] left;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            left <= '0;
         end else if (wr_stb && addr == OFS_SUBRST && wdata[k] && left == '0) begin
            left <= RC_W'(RST_CYCLES);
         end else if (left != '0) begin
            left <= left - 1'b1;
         end
      end
      assign sub_rst[k] = (left != '0);
   end
endmodule

// File: rtl/pkt_resp_tx.sv
module pkt_resp_tx #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   output logic              out_last
);
   localparam int unsigned NB   = DATA_W / 8;
   localparam int unsigned NB_W = $clog2(NB + 1);

   logic [DATA_W-1:0] sh;
   logic [NB_W-1:0]   left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
      end else if (load) begin
         sh   <= word;
         left <= NB_W'(NB);
      end else if (left != '0) begin
         sh   <= sh >> 8;
         left <= left - 1'b1;
      end
   end

   assign out_valid = (left != '0);
   assign out_byte  = out_valid ? sh[7:0] : 8'h00;
   assign out_last  = (left == NB_W'(1));
endmodule

// File: rtl/pkt_reg_slave.sv
module pkt_reg_slave
   import pkt_reg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter logic [31:0] ID_VALUE     = 32'h5E11_0A07,
   parameter int unsigned RST_CYCLES   = 16,
   parameter int unsigned LANES        = 5,
   parameter bit          EXT_EN       = 1'b1,
   parameter logic [15:0] EXT_BASE     = 16'h0400,
   parameter int unsigned EXT_LOW_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic             in_kind,
   input  logic [7:0]       in_byte,
   output logic             reg_wr_en,
   output logic             reg_rd_en,
   output logic [15:0]      reg_addr,
   output logic [31:0]      reg_wdata,
   input  logic [31:0]      reg_rdata,
   output logic             out_valid,
   output logic [7:0]       out_byte,
   output logic             out_last,
   output logic [5:0]       sub_rst,
   output logic [4:0]       lane_en_a,
   output logic [4:0]       lane_en_b,
   output logic             start_a,
   output logic             start_b,
   output logic             len_err
);
   localparam int unsigned HI_W = ADDR_W - EXT_LOW_BITS;

   if (ADDR_W != 16 || DATA_W != 32 || LANES != 5) begin : g_bad_shape
      $error("pkt_reg_slave: port shape fixes ADDR_W=16, DATA_W=32, LANES=5");
   end
   if (EXT_LOW_BITS < 1 || EXT_LOW_BITS > 15) begin : g_bad_window
      $error("pkt_reg_slave: EXT_LOW_BITS out of range");
   end
   if (EXT_EN && (OFS_ID[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS] ||
                  OFS_SUBRST[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS] ||
                  OFS_LANE_A[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS] ||
                  OFS_LANE_B[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS] ||
                  OFS_START_A[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS] ||
                  OFS_START_B[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS]))
   begin : g_overlap
      $error("pkt_reg_slave: bus window overlaps an internal register");
   end

   logic              cmd_valid;
   logic              cmd_read;
   logic [15:0]       cmd_addr;
   logic [31:0]       cmd_data;
   logic              ext_hit;
   logic              int_hit;
   logic [31:0]       int_rdata;
   logic              rd_wait_q;
   logic              rd_ext_q;
   logic [31:0]       resp_word;

   pkt_rx_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .in_kind   (in_kind),
      .in_byte   (in_byte),
      .cmd_valid (cmd_valid),
      .cmd_read  (cmd_read),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .len_err   (len_err)
   );

   if (EXT_EN) begin : g_ext
      assign ext_hit = (cmd_addr[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS]);
   end else begin : g_no_ext
      assign ext_hit = 1'b0;
   end

   assign reg_wr_en = cmd_valid && !cmd_read && ext_hit;
   assign reg_rd_en = cmd_valid &&  cmd_read && ext_hit;
   assign reg_addr  = cmd_addr;
   assign reg_wdata = cmd_data;

   pkt_reg_bank #(
      .DATA_W     (DATA_W),
      .ID_VALUE   (ID_VALUE),
      .RST_CYCLES (RST_CYCLES),
      .LANES      (LANES)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (cmd_valid && !cmd_read && int_hit),
      .addr    (cmd_addr),
      .wdata   (cmd_data),
      .hit     (int_hit),
      .rdata   (int_rdata),
      .sub_rst (sub_rst),
      .lane_a  (lane_en_a),
      .lane_b  (lane_en_b),
      .start_a (start_a),
      .start_b (start_b)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_wait_q <= 1'b0;
         rd_ext_q  <= 1'b0;
      end else begin
         rd_wait_q <= cmd_valid && cmd_read;
         rd_ext_q  <= ext_hit;
      end
   end

   assign resp_word = rd_ext_q ? reg_rdata : int_rdata;

   pkt_resp_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rd_wait_q),
      .word      (resp_word),
      .out_valid (out_valid),
      .out_byte  (out_byte),
      .out_last  (out_last)
   );
endmodule

// File: rtl/pkt_reg_slave_chk.sv
module pkt_reg_slave_chk #(
   parameter int unsigned RST_CYCLES   = 16,
   parameter logic [15:0] EXT_BASE     = 16'h0400,
   parameter int unsigned EXT_LOW_BITS = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        reg_wr_en,
   input logic        reg_rd_en,
   input logic [15:0] reg_addr,
   input logic        out_valid,
   input logic        out_last,
   input logic        len_err,
   input logic [5:0]  sub_rst
);
   localparam int unsigned RUN_W = $clog2(RST_CYCLES + 2) + 1;

   assert_wr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   assert_wr_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> reg_addr[15:EXT_LOW_BITS] == EXT_BASE[15:EXT_LOW_BITS]);

   assert_rd_to_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> ##2 (out_valid && !out_last));

   assert_last_is_fourth_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && $past(out_valid, 1) && $past(out_valid, 2)
                    && $past(out_valid, 3)));

   assert_resp_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   assert_host_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_valid);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |=> len_err);

   for (genvar k = 0; k < 6; k++) begin : g_run
      logic [RUN_W-1:0] run;
      always_ff @(posedge clk) begin
         if (!rst_n)          run <= '0;
         else if (sub_rst[k]) run <= run + 1'b1;
         else                 run <= '0;
      end
      assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!sub_rst[k] && run != '0) |-> run == RUN_W'(RST_CYCLES));
   end
endmodule

bind pkt_reg_slave pkt_reg_slave_chk #(
   .RST_CYCLES   (RST_CYCLES),
   .EXT_BASE     (EXT_BASE),
   .EXT_LOW_BITS (EXT_LOW_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .reg_wr_en (reg_wr_en),
   .reg_rd_en (reg_rd_en),
   .reg_addr  (reg_addr),
   .out_valid (out_valid),
   .out_last  (out_last),
   .len_err   (len_err),
   .sub_rst   (sub_rst)
);

// File: tb/pkt_reg_slave_tb.sv
module pkt_reg_slave_tb;
   localparam logic [31:0] ID_VAL = 32'h5E11_0A07;
   localparam int RSTC = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_kind = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic reg_wr_en, reg_rd_en, out_valid, out_last, start_a, start_b, len_err;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [7:0] out_byte;
   logic [5:0] sub_rst;
   logic [4:0] lane_en_a, lane_en_b;

   always #5 clk = ~clk;

   assign reg_rdata = {reg_addr ^ 16'h5A5A, ~reg_addr};

   pkt_reg_slave #(.ID_VALUE(ID_VAL), .RST_CYCLES(RSTC)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_kind(in_kind), .in_byte(in_byte),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
      .out_byte(out_byte), .out_last(out_last), .sub_rst(sub_rst),
      .lane_en_a(lane_en_a), .lane_en_b(lane_en_b), .start_a(start_a),
      .start_b(start_b), .len_err(len_err)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   int wr_cnt = 0, rd_cnt = 0, rx_n = 0;
   logic [15:0] last_wa;
   logic [31:0] last_wd;
   logic [7:0] rx_b [0:255];
   logic       rx_l [0:255];
   int run [6];
   int last_len [6];
   int pulses [6];

   initial for (int k = 0; k < 6; k++) begin run[k] = 0; last_len[k] = 0; pulses[k] = 0; end

   always @(negedge clk) begin
      if (reg_wr_en) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
      if (reg_rd_en) rd_cnt++;
      if (out_valid && rx_n < 256) begin rx_b[rx_n] = out_byte; rx_l[rx_n] = out_last; rx_n++; end
      for (int k = 0; k < 6; k++) begin
         if (sub_rst[k]) run[k]++;
         else if (run[k] != 0) begin last_len[k] = run[k]; pulses[k]++; run[k] = 0; end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_pkt(input logic kind, input logic [15:0] a, input logic [31:0] d,
                           input int n, input logic with_sop);
      logic [7:0] b [8];
      b[0] = a[7:0];  b[1] = a[15:8];
      b[2] = d[7:0];  b[3] = d[15:8]; b[4] = d[23:16]; b[5] = d[31:24];
      b[6] = 8'hEE;   b[7] = 8'hEE;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = with_sop && (i == 0); in_eop = (i == n - 1);
         in_kind = kind; in_byte = b[i];
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d);
      send_pkt(1'b0, a, d, 6, 1'b1);
   endtask

   task automatic do_read(input string req, input logic [15:0] a, output logic [31:0] w);
      int n0 = rx_n;
      send_pkt(1'b1, a, 32'h0, 2, 1'b1);
      for (int t = 0; t < 20 && rx_n < n0 + 4; t++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk({req, " response byte count"}, rx_n - n0, 4);
      w = {rx_b[n0+3], rx_b[n0+2], rx_b[n0+1], rx_b[n0]};
      chk({req, " out_last on fourth byte only"},
          {28'h0, rx_l[n0+3], rx_l[n0+2], rx_l[n0+1], rx_l[n0]}, 32'h8);
   endtask

   task automatic t_reset_R10;
      chk("R10 reset outputs", {len_err, start_a, start_b, out_valid, reg_wr_en, reg_rd_en,
          sub_rst, lane_en_a, lane_en_b}, 32'h0);
   endtask

   task automatic t_ext_write_R1;
      int c0 = wr_cnt;
      do_write(16'h0412, 32'hA1B2_C3D4);
      chk("R1 one write strobe", wr_cnt - c0, 1);
      chk("R1 write offset", {16'h0, last_wa}, 32'h0412);
      chk("R1 write data", last_wd, 32'hA1B2_C3D4);
      do_write(16'h04FE, 32'h0000_0001);
      chk("R1 second write data", last_wd, 32'h0000_0001);
   endtask

   task automatic t_ext_read_R9;
      logic [31:0] w;
      int c0 = rd_cnt;
      do_read("R9", 16'h0437, w);
      chk("R9 one read strobe", rd_cnt - c0, 1);
      chk("R9/R2 bus read word", w, {16'h0437 ^ 16'h5A5A, ~16'h0437});
   endtask

   task automatic t_id_R3;
      logic [31:0] w;
      do_read("R3", 16'h0580, w);
      chk("R3 id value", w, ID_VAL);
      do_write(16'h0580, 32'h1234_5678);
      do_read("R3", 16'h0580, w);
      chk("R3 id unchanged after write", w, ID_VAL);
   endtask

   task automatic t_subrst_R4;
      logic [31:0] w;
      do_write(16'h0504, 32'h0000_0005);
      do_read("R4", 16'h0504, w);
      chk("R4 active bits readback", w, 32'h5);
      repeat (25) @(negedge clk);
      chk("R4 bit0 pulse length", last_len[0], RSTC);
      chk("R4 bit2 pulse length", last_len[2], RSTC);
      chk("R4 bit1 untouched", pulses[1], 0);
      chk("R4 cleared", {26'h0, sub_rst}, 32'h0);
      do_read("R4", 16'h0504, w);
      chk("R4 readback after clear", w, 32'h0);
      do_write(16'h0504, 32'h0000_0020);
      do_write(16'h0504, 32'h0000_0020);
      repeat (25) @(negedge clk);
      chk("R4 no retrigger, bit5 length", last_len[5], RSTC);
      chk("R4 bit5 one pulse", pulses[5], 1);
   endtask

   task automatic t_lane_R5;
      logic [31:0] w;
      do_write(16'h0134, 32'hFFFF_FFFF);
      chk("R5 lane_en_a all lanes", {27'h0, lane_en_a}, 32'h1F);
      do_read("R5", 16'h0134, w);
      chk("R5 lane a readback masked", w, 32'h1F);
      do_write(16'h0210, 32'h0000_0013);
      chk("R5 lane_en_b clock+lanes0,3", {27'h0, lane_en_b}, 32'h13);
      do_read("R5", 16'h0210, w);
      chk("R5 lane b readback", w, 32'h13);
   endtask

   task automatic t_start_R6;
      do_write(16'h0104, 32'h1);
      chk("R6 start_a set, start_b low", {30'h0, start_a, start_b}, 32'h2);
      do_write(16'h0204, 32'h1);
      chk("R6 start_b set", {31'h0, start_b}, 32'h1);
      do_write(16'h0104, 32'h0);
      chk("R6 start_a cleared", {30'h0, start_a, start_b}, 32'h1);
   endtask

   task automatic t_stray_R11;
      send_pkt(1'b0, 16'h0134, 32'h0, 6, 1'b0);
      chk("R11 stray bytes leave lane_en_a", {27'h0, lane_en_a}, 32'h1F);
      chk("R11 stray bytes set no error", {31'h0, len_err}, 32'h0);
   endtask

   task automatic t_unmapped_R8;
      logic [31:0] w;
      int c0 = wr_cnt;
      do_write(16'h0700, 32'hFFFF_FFFF);
      chk("R8 no strobe on unmapped write", wr_cnt - c0, 0);
      chk("R8 outputs unchanged", {lane_en_a, lane_en_b, start_a, start_b}, {5'h1F, 5'h13, 1'b0, 1'b1});
      do_read("R8", 16'h0700, w);
      chk("R8 unmapped read zero", w, 32'h0);
      do_read("R8", 16'h0138, w);
      chk("R8 near-miss read zero", w, 32'h0);
   endtask

   task automatic t_badlen_R7;
      int c0 = wr_cnt;
      int n0;
      send_pkt(1'b0, 16'h0134, 32'h0, 5, 1'b1);
      chk("R7 short write ignored", {27'h0, lane_en_a}, 32'h1F);
      chk("R7 len_err set", {31'h0, len_err}, 32'h1);
      send_pkt(1'b0, 16'h0420, 32'h5, 7, 1'b1);
      chk("R7 long write no strobe", wr_cnt - c0, 0);
      n0 = rx_n;
      send_pkt(1'b1, 16'h0580, 32'h0, 3, 1'b1);
      repeat (8) @(negedge clk);
      chk("R7 long read no response", rx_n - n0, 0);
      do_write(16'h0134, 32'h2);
      chk("R7 good write after error", {27'h0, lane_en_a}, 32'h2);
      chk("R7 len_err sticky", {31'h0, len_err}, 32'h1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset_R10();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_R10();
      t_ext_write_R1();
      t_ext_read_R9();
      t_id_R3();
      t_subrst_R4();
      t_lane_R5();
      t_start_R6();
      t_stray_R11();
      t_unmapped_R8();
      t_badlen_R7();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule